// File: doc/BRIEF.md
# Synchronous Integer-Ratio Clock Converter

This block carries one valid/ready payload channel between two clock domains. Both clocks come from one source with zero phase offset, and their frequencies differ by a fixed integer factor. One clock is the fast clock and the other is the slow clock. A parameter sets the factor, and a second parameter says whether the slave-side (input) channel sits on the fast clock or on the slow clock.

All decisions are taken in the fast domain. A register in the slow domain flips on every slow edge. The fast domain samples it, and a change in the sampled value marks the fast cycle just after a shared edge. A phase counter locked to that mark then predicts the fast cycle that ends on the next shared edge. Handshake signals on the slow side are sampled and updated only at those shared edges. As a result, no synchronizer chain and no dual-clock FIFO are needed. Payload crosses with no delay beyond waiting for the next shared edge.

Use it where a fast and a slow part of a design are clocked from the same source at a fixed ratio of 2, 3, 4, 8 or 16. The block trusts the clock relationship and does not check it.

Top module: `sync_ratio_conv`

## Requirements
- R1: `RATIO` sets the number of fast cycles per slow cycle and takes the values 2, 3, 4, 8 or 16. `FAST_IS_SRC`=1 places the slave-side channel on `fast_clk` and the master-side channel on `slow_clk`. `FAST_IS_SRC`=0 does the reverse.
- R2: After both resets are released, the block makes no handshake on either side until a slow edge has been seen and the phase counter has locked. After lock, the counter prediction agrees with every later observed slow edge.
- R3: With the fast side as source, `s_ready` is high only in the fast cycle whose closing edge is also a slow-clock edge.
- R4: With the fast side as source, `m_valid` and `m_data` change only at shared edges. Once raised, they stay constant until a shared edge where `m_ready` is high.
- R5: With the slow side as source, `s_ready` changes only at shared edges, and each slow-side beat reaches the fast side exactly once.
- R6: When the far side never stalls, the slow-side interface moves one beat in every slow cycle, in both directions.
- R7: Beats arrive in the order they were sent, with none lost and none repeated, under any mix of valid and ready stalls on both sides. A fast-side `m_valid` that is not accepted holds its data.
- R8: Both resets are synchronous and active-low and are applied together. While they are low, `s_ready` and `m_valid` are 0.
- R9: With the slow side as source, the fast-side buffer holds at most two beats. When it cannot take another beat at the next shared edge, `s_ready` is withdrawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Faster of the two clocks; all converter state runs on it |
| fast_rst_n | input | 1 | Synchronous active-low reset, fast domain |
| slow_clk | input | 1 | Slower clock, edge-aligned to `fast_clk` at ratio `RATIO` |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| s_valid | input | 1 | Slave-side beat offered |
| s_ready | output | 1 | Slave-side beat taken at the next edge of its clock |
| s_data | input | DATA_W | Slave-side payload |
| m_valid | output | 1 | Master-side beat offered |
| m_ready | input | 1 | Master-side consumer accepts |
| m_data | output | DATA_W | Master-side payload |

## Verification
The hardest case to reach from the ports is the slow-to-fast buffer filling to two beats. This needs a slow source that offers a beat in every slow cycle while the fast consumer stalls across a shared edge. The bench sweeps valid and ready densities of 100, 50 and 20 percent on both sides, so full-rate sources meet sparse consumers in several slow cycles per phase. It also times every `s_ready` pulse and every `s_ready` change against the known slow-edge grid, since that alignment is what the block exists to provide.

// File: rtl/sxc_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the synchronous ratio converter.
// Assumes ratios are small integers (2..16).
package sxc_pkg;

    // Width of a counter that holds phases 0..ratio-1.
    function automatic int unsigned phase_bits(input int unsigned ratio);
        return (ratio <= 2) ? 1 : $clog2(ratio);
    endfunction

endpackage

// File: rtl/sxc_edge_track.sv
`timescale 1ns/1ps
// Finds the fast cycles that end on a slow-clock edge.
// What it does: a slow-domain register flips on every slow edge. The fast
// domain samples it, and a mismatch marks the fast cycle right after a
// shared edge. A modulo-RATIO phase counter is reloaded there and predicts
// the next shared edge.
// Assumes: the clocks share a source, are edge-aligned, and run at an exact
// integer ratio. Both resets are released together.
module sxc_edge_track #(
    parameter int unsigned RATIO = 4
) (
    input  logic fast_clk,
    input  logic fast_rst_n,
    input  logic slow_clk,
    input  logic slow_rst_n,
    output logic at_shared
);
    localparam int unsigned PW = sxc_pkg::phase_bits(RATIO);
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic          slow_tog;
    logic          tog_seen;
    logic          locked;
    logic [PW-1:0] phase;
    logic          edge_seen;

    // Slow domain: flip once per slow edge.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) slow_tog <= 1'b0;
        else             slow_tog <= ~slow_tog;
    end

    // Mismatch exists only in the fast cycle just after a shared edge.
    assign edge_seen = (slow_tog != tog_seen);

    // Fast domain: sample the flip bit, lock and advance the phase counter.
    always_ff @(posedge fast_clk) begin
        if (!fast_rst_n) begin
            tog_seen <= 1'b0;
            locked   <= 1'b0;
            phase    <= '0;
        end else begin
            tog_seen <= slow_tog;
            if (edge_seen) begin
                locked <= 1'b1;
                phase  <= ONE;
            end else if (phase == LAST) begin
                phase  <= '0;
            end else begin
                phase  <= phase + ONE;
            end
        end
    end

    // The cycle that closes on a shared edge.
    assign at_shared = locked && (phase == LAST);

    AST_PHASE_AGREE: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
        (locked && edge_seen) |-> (phase == '0)); // R2

endmodule

// File: rtl/sxc_fast_to_slow.sv
`timescale 1ns/1ps
// Fast-domain source feeding a slow-domain sink.
// What it does: an output register is loaded from the fast side only at a
// shared edge, so the slow consumer sees valid/data constant for whole slow
// cycles. The fast side's ready is open only in the cycle that closes on a
// shared edge.
// Assumes: m_ready is a slow-domain signal, stable between slow edges.
module sxc_fast_to_slow #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_shared,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data
);
    logic              out_v;
    logic [DATA_W-1:0] out_d;

    // Take a new beat only at a shared edge where the output slot frees up.
    assign s_ready = at_shared && (!out_v || m_ready);

    // Output slot: drain and refill only on shared edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_d <= '0;
        end else if (at_shared) begin
            if (out_v && m_ready) out_v <= 1'b0;
            if (s_valid && s_ready) begin
                out_v <= 1'b1;
                out_d <= s_data;
            end
        end
    end

    assign m_valid = out_v;
    assign m_data  = out_d;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v && !(at_shared && m_ready)) |=> (out_v && $stable(out_d))); // R4

endmodule

// File: rtl/sxc_slow_to_fast.sv
`timescale 1ns/1ps
// Slow-domain source feeding a fast-domain sink.
// What it does: slow beats are captured into a two-entry fast-domain buffer
// only at shared edges, so each slow beat is taken once. The slow-facing
// ready is a register updated only at shared edges. It stays open while the
// buffer is guaranteed room at the next shared edge, which lets the slow
// side stream every slow cycle.
// Assumes: s_valid/s_data are slow-domain signals, stable between slow edges.
module sxc_slow_to_fast #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_shared,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data
);
    localparam int unsigned DEPTH = 2;

    logic [DATA_W-1:0] slot [DEPTH];
    logic              wr_ptr;
    logic              rd_ptr;
    logic [1:0]        cnt;
    logic [1:0]        cnt_nxt;
    logic              rdy_q;
    logic              push;
    logic              pop;

    assign push = at_shared && s_valid && rdy_q;
    assign pop  = m_valid && m_ready;

    // Occupancy after this edge.
    always_comb begin
        cnt_nxt = cnt;
        if (push && !pop)      cnt_nxt = cnt + 2'd1;
        else if (!push && pop) cnt_nxt = cnt - 2'd1;
    end

    // Storage slots, one write port each.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                       slot[i] <= '0;
            else if (push && (wr_ptr == i[0])) slot[i] <= s_data;
        end
    end

    // Pointers, occupancy and the slow-facing ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= 1'b0;
            rd_ptr <= 1'b0;
            cnt    <= '0;
            rdy_q  <= 1'b0;
        end else begin
            if (push) wr_ptr <= ~wr_ptr;
            if (pop)  rd_ptr <= ~rd_ptr;
            cnt <= cnt_nxt;
            if (at_shared) rdy_q <= (cnt_nxt < 2'd2);
        end
    end

    assign s_ready = rdy_q;
    assign m_valid = (cnt != 2'd0);
    assign m_data  = slot[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt != 2'd2)); // R9

    AST_M_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R7

endmodule

// File: rtl/sync_ratio_conv.sv
`timescale 1ns/1ps
// Synchronous integer-ratio clock converter for one valid/ready channel.
// What it does: the edge tracker marks fast cycles that close on a slow
// edge. One of two datapaths is chosen by FAST_IS_SRC, and it exchanges
// handshakes with the slow side only in those cycles.
// Assumes: one clock source, zero phase offset, ratio RATIO in
// {2,3,4,8,16}; resets applied and released together.
module sync_ratio_conv #(
    parameter int unsigned RATIO       = 4,
    parameter bit          FAST_IS_SRC = 1'b1,
    parameter int unsigned DATA_W      = 32
) (
    input  logic              fast_clk,
    input  logic              fast_rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data
);
    logic at_shared;

    sxc_edge_track #(.RATIO(RATIO)) u_track (
        .fast_clk   (fast_clk),
        .fast_rst_n (fast_rst_n),
        .slow_clk   (slow_clk),
        .slow_rst_n (slow_rst_n),
        .at_shared  (at_shared)
    );

    // Pick the datapath for the configured direction.
    if (FAST_IS_SRC) begin : g_f2s
        sxc_fast_to_slow #(.DATA_W(DATA_W)) u_path (
            .clk       (fast_clk),
            .rst_n     (fast_rst_n),
            .at_shared (at_shared),
            .s_valid   (s_valid),
            .s_ready   (s_ready),
            .s_data    (s_data),
            .m_valid   (m_valid),
            .m_ready   (m_ready),
            .m_data    (m_data)
        );
    end else begin : g_s2f
        sxc_slow_to_fast #(.DATA_W(DATA_W)) u_path (
            .clk       (fast_clk),
            .rst_n     (fast_rst_n),
            .at_shared (at_shared),
            .s_valid   (s_valid),
            .s_ready   (s_ready),
            .s_data    (s_data),
            .m_valid   (m_valid),
            .m_ready   (m_ready),
            .m_data    (m_data)
        );
    end

endmodule

// File: tb/sync_ratio_conv_tb_top.sv
`timescale 1ns/1ps
// Bench: one fast-to-slow converter at ratio 4 and one slow-to-fast
// converter at ratio 3. The bench sweeps valid/ready densities on both
// sides and scores against sequence numbers.
module sync_ratio_conv_tb_top;
    localparam int DW = 16;

    logic fclk  = 1'b1;   // 20 ns, rises at 20k
    logic s3clk = 1'b1;   // 60 ns, rises at 60k
    logic s4clk = 1'b1;   // 80 ns, rises at 80k
    logic rst_n = 1'b0;

    logic          a_s_valid = 1'b0, a_s_ready, a_m_valid, a_m_ready = 1'b0;
    logic [DW-1:0] a_s_data = '0, a_m_data;
    logic          b_s_valid = 1'b0, b_s_ready, b_m_valid, b_m_ready = 1'b0;
    logic [DW-1:0] b_s_data = '0, b_m_data;

    int checks = 0, errors = 0;
    int vpct = 100, rpct = 100;
    bit stop = 1'b0, running = 1'b0;
    int a_sent = 0, a_rcvd = 0, b_sent = 0, b_rcvd = 0;

    // Fast-side source, slow-side sink (R1: FAST_IS_SRC=1).
    sync_ratio_conv #(.RATIO(4), .FAST_IS_SRC(1'b1), .DATA_W(DW)) dut_i (
        .fast_clk(fclk), .fast_rst_n(rst_n), .slow_clk(s4clk), .slow_rst_n(rst_n),
        .s_valid(a_s_valid), .s_ready(a_s_ready), .s_data(a_s_data),
        .m_valid(a_m_valid), .m_ready(a_m_ready), .m_data(a_m_data));

    // Slow-side source, fast-side sink (R1: FAST_IS_SRC=0).
    sync_ratio_conv #(.RATIO(3), .FAST_IS_SRC(1'b0), .DATA_W(DW)) dut_rev_i (
        .fast_clk(fclk), .fast_rst_n(rst_n), .slow_clk(s3clk), .slow_rst_n(rst_n),
        .s_valid(b_s_valid), .s_ready(b_s_ready), .s_data(b_s_data),
        .m_valid(b_m_valid), .m_ready(b_m_ready), .m_data(b_m_data));

    // All clocks from one process: edge-aligned by construction.
    initial begin
        int hc = 0;
        forever begin
            #10;
            hc++;
            fclk = ~fclk;
            if (hc % 3 == 0) s3clk = ~s3clk;
            if (hc % 4 == 0) s4clk = ~s4clk;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Source A on fast clock.
    initial begin
        bit fire = 1'b0;
        wait (running);
        forever begin
            @(negedge fclk);
            if (!a_s_valid || fire) begin
                if (!stop && ($urandom_range(99) < vpct)) begin
                    a_s_valid = 1'b1;
                    a_s_data  = a_sent[DW-1:0];
                end else a_s_valid = 1'b0;
            end
            #1;
            // R3: ready only in the cycle closing on an 80 ns grid edge
            if (a_s_ready) check((($time + 9) % 80) == 0, "R3 ready off shared edge",
                                 int'(($time + 9) % 80), 0);
            fire = a_s_valid && a_s_ready;
            if (fire) a_sent++;
        end
    end

    // Sink A on slow clock (ratio 4).
    initial begin
        bit          held = 1'b0;
        logic [DW-1:0] held_d = '0;
        forever begin
            @(negedge s4clk);
            #5;
            a_m_ready = stop || ($urandom_range(99) < rpct);
            #1;
            if (held) begin
                check(a_m_valid === 1'b1, "R4 m_valid dropped", a_m_valid, 1);
                check(a_m_data === held_d, "R4 m_data changed", a_m_data, held_d);
            end
            if (a_m_valid && a_m_ready) begin
                check(a_m_data === a_rcvd[DW-1:0], "R7 A order", a_m_data, a_rcvd[DW-1:0]);
                a_rcvd++;
            end
            held   = a_m_valid && !a_m_ready;
            held_d = a_m_data;
        end
    end

    // Source B on slow clock (ratio 3).
    initial begin
        bit fire = 1'b0;
        wait (running);
        forever begin
            @(negedge s3clk);
            if (!b_s_valid || fire) begin
                if (!stop && ($urandom_range(99) < vpct)) begin
                    b_s_valid = 1'b1;
                    b_s_data  = b_sent[DW-1:0];
                end else b_s_valid = 1'b0;
            end
            #1;
            fire = b_s_valid && b_s_ready;
            if (fire) b_sent++;
        end
    end

    // Sink B on fast clock; also times s_ready changes against the 60 ns grid.
    initial begin
        logic prev_rdy = 1'b0;
        forever begin
            @(negedge fclk);
            b_m_ready = stop || ($urandom_range(99) < rpct);
            #1;
            if (b_s_ready !== prev_rdy)
                check((($time - 11) % 60) == 0, "R5 s_ready moved off shared edge",
                      int'(($time - 11) % 60), 0);
            prev_rdy = b_s_ready;
            if (b_m_valid && b_m_ready) begin
                check(b_m_data === b_rcvd[DW-1:0], "R5 R7 B order/once", b_m_data, b_rcvd[DW-1:0]);
                b_rcvd++;
            end
        end
    end

    // Main sequence.
    initial begin
        int a0, b0;
        repeat (12) @(negedge fclk);
        #1;
        check(a_s_ready === 1'b0, "R8 A s_ready in reset", a_s_ready, 0);
        check(a_m_valid === 1'b0, "R8 A m_valid in reset", a_m_valid, 0);
        check(b_s_ready === 1'b0, "R8 B s_ready in reset", b_s_ready, 0);
        check(b_m_valid === 1'b0, "R8 B m_valid in reset", b_m_valid, 0);
        @(negedge fclk);
        rst_n = 1'b1;
        // R2: no ready before lock (at least 70 ns after release)
        for (int k = 0; k < 4; k++) begin
            #1;
            check(a_s_ready === 1'b0, "R2 A ready before lock", a_s_ready, 0);
            check(b_s_ready === 1'b0, "R2 B ready before lock", b_s_ready, 0);
            @(negedge fclk);
        end
        running = 1'b1;

        // R6: full rate both ways.
        vpct = 100; rpct = 100;
        repeat (40) @(negedge fclk);
        a0 = a_rcvd; b0 = b_rcvd;
        #3200;
        check((a_rcvd - a0) >= 39, "R6 A beats per slow cycle", a_rcvd - a0, 40);
        check((b_rcvd - b0) >= 52, "R6 B beats per slow cycle", b_rcvd - b0, 53);

        // R7 R9: density sweep.
        for (int vi = 0; vi < 3; vi++) begin
            for (int ri = 0; ri < 3; ri++) begin
                vpct = (vi == 0) ? 100 : (vi == 1) ? 50 : 20;
                rpct = (ri == 0) ? 100 : (ri == 1) ? 50 : 20;
                repeat (300) @(negedge fclk);
            end
        end

        stop = 1'b1;
        repeat (300) @(negedge fclk);
        #1;
        check(a_sent == a_rcvd, "R7 A none lost", a_rcvd, a_sent);
        check(b_sent == b_rcvd, "R7 B none lost", b_rcvd, b_sent);
        check(a_sent > 200, "R7 A progress", a_sent, 200);
        check(b_sent > 200, "R7 B progress", b_sent, 200);
        finish_run();
    end

    // Watchdog.
    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule